// File: doc/BRIEF.md
# Transmit descriptor ring walker

This block steps through per-channel rings of transmit buffer descriptors kept in an external descriptor memory. It hands each ready buffer to a downstream sender. Every channel has a base byte address and a current byte offset into its ring. The walker serves one channel at a time. It reads one 64-bit descriptor, checks whether the host has marked it ready, and presents the buffer pointer and length to the sender until the sender reports completion. It then writes the status back with the ready bit cleared, which returns the descriptor to the host, and moves the channel to its next descriptor.

A channel starts only on a transmit command. When the walker meets a descriptor that is not ready, it does one of two things, chosen per channel by a configuration flag:
- It parks the channel and fetches the descriptor again on each pulse of that channel's rate tick.
- It halts the channel, raises the channel's idle flag, and waits for a fresh command.

Channels that want a descriptor fetched are granted in round-robin order.

Top module: `txw_ring_walker`

## Requirements
- R1: After reset `snd_valid`, `mem_rd_en` and `mem_wr_en` are low, every `chan_idle` bit is high, and every channel offset is zero.
- R2: A `cmd_start` pulse on an idle channel causes a single-cycle read with `mem_rd_addr` = (base + offset) >> 3, the 8-byte word address. Read data is taken one cycle after `mem_rd_en`.
- R3: The descriptor word is laid out as follows: status in [15:0] (bit 15 ready, bit 13 wrap, bit 11 last), length in [31:16], pointer in [63:32]. A descriptor with bit 15 set drives `snd_valid` with its pointer, length, last flag and channel. These stay steady until `snd_done` is seen with `snd_valid`.
- R4: The cycle after completion, `mem_wr_en` writes `mem_wr_status` to the same word address. The written status equals the descriptor status with bit 15 cleared and all other bits kept.
- R5: After completion the channel offset grows by 8, or returns to 0 when the finished descriptor had bit 13 set. The next descriptor is then fetched without any further command.
- R6: When `cfg_halt` is low and a fetched descriptor is not ready, the channel issues no further read until its `rate_tick` pulses. Each tick then causes a re-read of the same descriptor, and `chan_idle` stays low meanwhile.
- R7: When `cfg_halt` is high and a fetched descriptor is not ready, the channel raises `chan_idle`. Rate ticks are then ignored and cause no read, and only a new `cmd_start` resumes it at the same offset.
- R8: Among channels waiting for a fetch, grants rotate round-robin, starting from the channel after the one granted last. After reset, channel 0 has top priority.
- R9: Only one descriptor is in flight: no read or write happens while `snd_valid` is high, and a read is never longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | NUM_CH | Per-channel transmit command pulse |
| rate_tick | input | NUM_CH | Per-channel rate tick that paces re-polling |
| cfg_base | input | NUM_CH*ADDR_W | Per-channel ring base byte address, channel c in bits [c*ADDR_W +: ADDR_W] |
| cfg_halt | input | NUM_CH | Per-channel flag: halt instead of polling on a not-ready descriptor |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | ADDR_W-3 | Descriptor word address |
| mem_rd_data | input | 64 | Descriptor word, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Status write-back strobe |
| mem_wr_addr | output | ADDR_W-3 | Write-back word address |
| mem_wr_status | output | 16 | Status field to write into bits [15:0] of the word |
| snd_valid | output | 1 | Buffer offered to the sender |
| snd_chan | output | max(1,$clog2(NUM_CH)) | Channel of the offered buffer |
| snd_ptr | output | 32 | Buffer pointer |
| snd_len | output | 16 | Buffer length |
| snd_last | output | 1 | Last flag of the descriptor |
| snd_done | input | 1 | Sender finished the offered buffer |
| chan_idle | output | NUM_CH | Channel not running (never started or halted) |

## Verification
The bench builds the walker with NUM_CH = 4 and ADDR_W = 12, which gives a 512-word descriptor memory. With these values, one run can exercise all of the following:
- a polling channel and a halting channel side by side;
- a three-entry ring that wraps back to its base;
- two channels started in the same cycle, whose grants must alternate.

The small address space keeps every ring base apart. Four channels are enough for the arbiter pointer to move past the last-granted channel and wrap within the run.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int DESC_W     = 64;
  localparam int DESC_BYTES = 8;
  localparam int STAT_W     = 16;
  localparam int LEN_W      = 16;
  localparam int PTR_W      = 32;
  localparam int RDY_BIT    = 15;
  localparam int WRAP_BIT   = 13;
  localparam int LAST_BIT   = 11;
  localparam int LEN_LSB    = STAT_W;
  localparam int PTR_LSB    = STAT_W + LEN_W;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_FETCH = 2'd1,
    CH_BUSY  = 2'd2,
    CH_POLL  = 2'd3
  } ch_state_e;

  typedef enum logic [2:0] {
    W_IDLE = 3'd0,
    W_RD   = 3'd1,
    W_EVAL = 3'd2,
    W_SEND = 3'd3,
    W_WB   = 3'd4
  } walk_state_e;
endpackage

// File: rtl/txw_chan.sv
module txw_chan
  import txw_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             take_i,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic             nready_i,
  output logic             req_o,
  output logic             idle_o,
  output logic [OFF_W-1:0] off_o
);
  ch_state_e        st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             off_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CH_OFF:   if (start_i) st_d = CH_FETCH;
      CH_FETCH: if (take_i) st_d = CH_BUSY;
      CH_BUSY: begin
        if (adv_i)         st_d = CH_FETCH;
        else if (nready_i) st_d = halt_i ? CH_OFF : CH_POLL;
      end
      CH_POLL:  if (tick_i) st_d = CH_FETCH;
      default:  st_d = CH_OFF;
    endcase
  end

  assign off_en = adv_i && (st_q == CH_BUSY);
  assign off_d  = wrap_i ? '0 : off_q + OFF_W'(DESC_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_OFF;
      off_q <= '0;
    end else begin
      st_q <= st_d;
      if (off_en) off_q <= off_d;
    end
  end

  assign req_o  = (st_q == CH_FETCH);
  assign idle_o = (st_q == CH_OFF);
  assign off_o  = off_q;
endmodule

// File: rtl/txw_rr_arb.sv
module txw_rr_arb #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic             take_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] last_q, last_d;
  logic             found;
  logic [IDX_W-1:0] pick;

  always_comb begin
    int unsigned k;
    found = 1'b0;
    pick  = '0;
    k     = 0;
    for (int i = 1; i <= N; i++) begin
      k = (int'(last_q) + i) % N;
      if (!found && req_i[k]) begin
        found = 1'b1;
        pick  = IDX_W'(k);
      end
    end
  end

  assign last_d = (take_i && found) ? pick : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDX_W'(N - 1);
    else        last_q <= last_d;
  end

  assign gnt_valid_o = found;
  assign gnt_idx_o   = pick;
endmodule

// File: rtl/txw_ring_walker.sv
module txw_ring_walker
  import txw_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WADDR_W = ADDR_W - 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        cmd_start,
  input  logic [NUM_CH-1:0]        rate_tick,
  input  logic [NUM_CH*ADDR_W-1:0] cfg_base,
  input  logic [NUM_CH-1:0]        cfg_halt,
  output logic                     mem_rd_en,
  output logic [WADDR_W-1:0]       mem_rd_addr,
  input  logic [63:0]              mem_rd_data,
  output logic                     mem_wr_en,
  output logic [WADDR_W-1:0]       mem_wr_addr,
  output logic [15:0]              mem_wr_status,
  output logic                     snd_valid,
  output logic [CH_W-1:0]          snd_chan,
  output logic [31:0]              snd_ptr,
  output logic [15:0]              snd_len,
  output logic                     snd_last,
  input  logic                     snd_done,
  output logic [NUM_CH-1:0]        chan_idle
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic [ADDR_W-1:0] base_arr [NUM_CH];
  logic [ADDR_W-1:0] off_arr  [NUM_CH];
  logic [NUM_CH-1:0] ch_req, take_vec, adv_vec, nr_vec;
  logic              gnt_valid, arb_take;
  logic [CH_W-1:0]   gnt_idx;

  walk_state_e       wst_q, wst_d;
  logic [CH_W-1:0]   cur_q, cur_d;
  logic [DESC_W-1:0] desc_q, desc_d;
  logic              desc_en;
  logic [ADDR_W-1:0] cur_addr;

  txw_rr_arb #(.N(NUM_CH)) u_arb (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .req_i       (ch_req),
    .take_i      (arb_take),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign base_arr[c] = cfg_base[c*ADDR_W +: ADDR_W];
    txw_chan #(.OFF_W(ADDR_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .start_i  (cmd_start[c]),
      .tick_i   (rate_tick[c]),
      .halt_i   (cfg_halt[c]),
      .take_i   (take_vec[c]),
      .adv_i    (adv_vec[c]),
      .wrap_i   (desc_q[WRAP_BIT]),
      .nready_i (nr_vec[c]),
      .req_o    (ch_req[c]),
      .idle_o   (chan_idle[c]),
      .off_o    (off_arr[c])
    );
  end

  assign arb_take = (wst_q == W_IDLE) && gnt_valid;
  assign cur_addr = base_arr[cur_q] + off_arr[cur_q];

  // Walker next-state logic
  always_comb begin
    wst_d    = wst_q;
    cur_d    = cur_q;
    desc_d   = mem_rd_data;
    desc_en  = 1'b0;
    take_vec = '0;
    adv_vec  = '0;
    nr_vec   = '0;
    unique case (wst_q)
      W_IDLE: begin
        if (gnt_valid) begin
          cur_d             = gnt_idx;
          take_vec[gnt_idx] = 1'b1;
          wst_d             = W_RD;
        end
      end
      W_RD:   wst_d = W_EVAL;
      W_EVAL: begin
        if (mem_rd_data[RDY_BIT]) begin
          desc_en = 1'b1;
          wst_d   = W_SEND;
        end else begin
          nr_vec[cur_q] = 1'b1;
          wst_d         = W_IDLE;
        end
      end
      W_SEND: if (snd_done) wst_d = W_WB;
      W_WB: begin
        adv_vec[cur_q] = 1'b1;
        wst_d          = W_IDLE;
      end
      default: wst_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wst_q  <= W_IDLE;
      cur_q  <= '0;
      desc_q <= '0;
    end else begin
      wst_q <= wst_d;
      cur_q <= cur_d;
      if (desc_en) desc_q <= desc_d;
    end
  end

  assign mem_rd_en     = (wst_q == W_RD);
  assign mem_rd_addr   = cur_addr[ADDR_W-1:3];
  assign mem_wr_en     = (wst_q == W_WB);
  assign mem_wr_addr   = cur_addr[ADDR_W-1:3];
  assign mem_wr_status = desc_q[STAT_W-1:0] & ~(16'(1) << RDY_BIT);

  assign snd_valid = (wst_q == W_SEND);
  assign snd_chan  = cur_q;
  assign snd_ptr   = desc_q[PTR_LSB +: PTR_W];
  assign snd_len   = desc_q[LEN_LSB +: LEN_W];
  assign snd_last  = desc_q[LAST_BIT];
endmodule

// File: rtl/txw_checker.sv
module txw_checker #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic            snd_valid,
  input logic            snd_done,
  input logic [CH_W-1:0] snd_chan,
  input logic [31:0]     snd_ptr,
  input logic [15:0]     snd_len,
  input logic            snd_last
);
  assert_one_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid |-> (!mem_rd_en && !mem_wr_en));

  assert_read_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R2: read data is evaluated the cycle after the strobe, so no offer can follow at once
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !snd_valid);

  assert_offer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_done) |=> (snd_valid && $stable(snd_ptr) && $stable(snd_len)
                                  && $stable(snd_chan) && $stable(snd_last)));

  assert_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && snd_done) |=> (mem_wr_en && !snd_valid));

  assert_write_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);
endmodule

bind txw_ring_walker txw_checker #(.CH_W(CH_W)) u_txw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .snd_valid (snd_valid),
  .snd_done  (snd_done),
  .snd_chan  (snd_chan),
  .snd_ptr   (snd_ptr),
  .snd_len   (snd_len),
  .snd_last  (snd_last)
);

// File: tb/txw_ring_walker_tb_top.sv
`timescale 1ns/1ps
module txw_ring_walker_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int WAW = AW - 3;

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] ptr;
    logic [15:0] len;
    logic        last;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  cmd_start, rate_tick, cfg_halt, chan_idle;
  logic [NCH*AW-1:0] cfg_base;
  logic            mem_rd_en, mem_wr_en, snd_valid, snd_last, snd_done;
  logic [WAW-1:0]  mem_rd_addr, mem_wr_addr;
  logic [63:0]     mem_rd_data;
  logic [15:0]     mem_wr_status, snd_len;
  logic [1:0]      snd_chan;
  logic [31:0]     snd_ptr;

  logic [63:0] mem [0:(1<<WAW)-1];
  item_t       exp_q[$];
  int          n_chk = 0, n_err = 0, n_sent = 0, n_rd = 0;
  logic [WAW-1:0] last_rd;
  bit          in_send = 0;
  int          hold = 0;
  bit          done_flag = 0;

  always #4 clk = ~clk;

  txw_ring_walker #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .rate_tick(rate_tick),
    .cfg_base(cfg_base), .cfg_halt(cfg_halt), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_status(mem_wr_status), .snd_valid(snd_valid),
    .snd_chan(snd_chan), .snd_ptr(snd_ptr), .snd_len(snd_len), .snd_last(snd_last),
    .snd_done(snd_done), .chan_idle(chan_idle)
  );

  // Descriptor memory model: one-cycle read, status-only write
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    if (mem_wr_en) mem[mem_wr_addr][15:0] <= mem_wr_status;
  end

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] mk_stat(input bit rdy, input bit wrp, input bit lst);
    return 16'(rdy) << 15 | 16'(wrp) << 13 | 16'(lst) << 11 | 16'h0005;
  endfunction

  task automatic put_desc(input int baddr, input bit rdy, input bit wrp, input bit lst,
                          input logic [15:0] len, input logic [31:0] ptr);
    mem[baddr >> 3] = {ptr, len, mk_stat(rdy, wrp, lst)};
  endtask

  task automatic expect_send(input int ch, input logic [31:0] ptr, input logic [15:0] len,
                             input bit lst);
    item_t it;
    it.ch = 2'(ch); it.ptr = ptr; it.len = len; it.last = lst;
    exp_q.push_back(it);
  endtask

  task automatic pulse_start(input logic [NCH-1:0] m);
    @(negedge clk); cmd_start = m;
    @(negedge clk); cmd_start = '0;
  endtask

  task automatic pulse_tick(input logic [NCH-1:0] m);
    @(negedge clk); rate_tick = m;
    @(negedge clk); rate_tick = '0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((exp_q.size() != 0 || in_send) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (12) @(negedge clk);
    chk_eq({tag, " scoreboard drained"}, 64'(exp_q.size()), 64'd0);
  endtask

  // Sender model and scoreboard monitor
  initial begin
    snd_done = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_rd_en) begin n_rd++; last_rd = mem_rd_addr; end
      if (snd_done) begin
        snd_done = 1'b0;
        in_send  = 0;
      end else if (snd_valid) begin
        if (!in_send) begin
          in_send = 1; hold = 0; n_sent++;
          if (exp_q.size() == 0) begin
            chk_eq("R3 R8 unexpected send", {32'd0, snd_ptr}, 64'd0);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            chk_eq("R3 R8 send channel", 64'(snd_chan), 64'(e.ch));
            chk_eq("R3 R8 send pointer", 64'(snd_ptr),  64'(e.ptr));
            chk_eq("R3 send length",     64'(snd_len),  64'(e.len));
            chk_eq("R3 send last flag",  64'(snd_last), 64'(e.last));
          end
        end
        hold++;
        if (hold >= 2) snd_done = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int rd0, s0;
    for (int i = 0; i < (1 << WAW); i++) mem[i] = '0;
    rst_n = 1'b0; cmd_start = '0; rate_tick = '0;
    cfg_halt = 4'b0010;
    cfg_base = {12'h400, 12'h300, 12'h200, 12'h100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_eq("R1 snd_valid", 64'(snd_valid), 64'd0);
    chk_eq("R1 mem_rd_en", 64'(mem_rd_en), 64'd0);
    chk_eq("R1 mem_wr_en", 64'(mem_wr_en), 64'd0);
    chk_eq("R1 chan_idle", 64'(chan_idle), 64'hF);

    // R2 R3 R5: channel 0, three-entry ring with wrap on the third
    put_desc(12'h100, 1, 0, 0, 16'd40,  32'hA000_0000);
    put_desc(12'h108, 1, 0, 0, 16'd52,  32'hA000_1000);
    put_desc(12'h110, 1, 1, 1, 16'd64,  32'hA000_2000);
    expect_send(0, 32'hA000_0000, 16'd40, 0);
    expect_send(0, 32'hA000_1000, 16'd52, 0);
    expect_send(0, 32'hA000_2000, 16'd64, 1);
    pulse_start(4'b0001);
    drain("R2 R5 ring walk");
    // R1: offset started at zero, first read hit the base; R5: wrap re-reads base
    chk_eq("R5 wrap re-read at base", 64'(last_rd), 64'(12'h100 >> 3));
    chk_eq("R6 polling channel not idle", 64'(chan_idle[0]), 64'd0);
    // R4 write-back cleared ready and kept other bits
    chk_eq("R4 status d0", 64'(mem[12'h100>>3][15:0]), 64'(mk_stat(0,0,0)));
    chk_eq("R4 status d1", 64'(mem[12'h108>>3][15:0]), 64'(mk_stat(0,0,0)));
    chk_eq("R4 status d2", 64'(mem[12'h110>>3][15:0]), 64'(mk_stat(0,1,1)));

    // R6: ready again, but no read until the rate tick
    put_desc(12'h100, 1, 0, 0, 16'd72, 32'hA000_3000);
    rd0 = n_rd; s0 = n_sent;
    repeat (20) @(negedge clk);
    chk_eq("R6 no read without tick", 64'(n_rd), 64'(rd0));
    chk_eq("R6 no send without tick", 64'(n_sent), 64'(s0));
    expect_send(0, 32'hA000_3000, 16'd72, 0);
    pulse_tick(4'b0001);
    drain("R6 tick re-poll");
    chk_eq("R6 send after tick", 64'(n_sent), 64'(s0 + 1));

    // R7: channel 1 halts on a not-ready descriptor
    put_desc(12'h200, 0, 0, 0, 16'd20, 32'hB000_0000);
    pulse_start(4'b0010);
    repeat (8) @(negedge clk);
    chk_eq("R2 read at base of ch1", 64'(last_rd), 64'(12'h200 >> 3));
    chk_eq("R7 idle raised on halt", 64'(chan_idle[1]), 64'd1);
    put_desc(12'h200, 1, 0, 0, 16'd20, 32'hB000_0000);
    rd0 = n_rd; s0 = n_sent;
    pulse_tick(4'b0010);
    repeat (20) @(negedge clk);
    chk_eq("R7 tick ignored no read", 64'(n_rd), 64'(rd0));
    chk_eq("R7 tick ignored no send", 64'(n_sent), 64'(s0));
    expect_send(1, 32'hB000_0000, 16'd20, 0);
    pulse_start(4'b0010);
    drain("R7 restart");
    chk_eq("R7 resumed send", 64'(n_sent), 64'(s0 + 1));
    chk_eq("R5 advanced then halted at ch1 offset 8", 64'(last_rd), 64'(12'h208 >> 3));
    chk_eq("R7 idle again", 64'(chan_idle[1]), 64'd1);

    // R8: channels 2 and 3 started together alternate
    put_desc(12'h300, 1, 0, 0, 16'd11, 32'hC000_0000);
    put_desc(12'h308, 1, 1, 0, 16'd12, 32'hC000_0008);
    put_desc(12'h400, 1, 0, 0, 16'd13, 32'hD000_0000);
    put_desc(12'h408, 1, 1, 1, 16'd14, 32'hD000_0008);
    expect_send(2, 32'hC000_0000, 16'd11, 0);
    expect_send(3, 32'hD000_0000, 16'd13, 0);
    expect_send(2, 32'hC000_0008, 16'd12, 0);
    expect_send(3, 32'hD000_0008, 16'd14, 1);
    pulse_start(4'b1100);
    drain("R8 round robin");
    chk_eq("R9 no stray offer at end", 64'(snd_valid), 64'd0);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule